// File: doc/BRIEF.md
# Trace Log Ring Buffer

This block records a wide status word on every clock edge into a circular on-chip buffer. It keeps recording until somebody asks it to stop. Software and a debug probe can then pull the recorded entries back out, one 64-bit doubleword per access. The traced word has no handshake, because the recorder never stalls the logic it observes. One entry is consumed per cycle for as long as logging is running.

Two independent requesters reach the block: a processor-side register port (`cpu_*`) and a debug-side port (`dbg_*`). Each requester sees two registers of its own, selected by `req_sel`:

- **Control/address register** (`req_sel=0`). Bits 63:32 hold the write pointer, counted in entries, ORed with the buffer depth. Bit 31 is that side's freeze flag. The low bits hold that side's read pointer, counted in doublewords.
- **Data register** (`req_sel=1`). Reading it returns the doubleword at the read pointer and then steps the pointer forward by one.

Because the depth is ORed into the pointer field, software can recover the buffer size as `1 << (31 - clz(word))`, where `clz` counts leading zeros of the 64-bit word. Logging halts while either side's freeze flag is set.

Each port uses valid/ready handshakes in both directions:

- **Requests.** A request moves on a cycle where `req_valid` and `req_ready` are both high. Once `req_valid` is raised, the fields must stay stable until that cycle. `req_ready` may depend on `req_valid` and on the request type.
- **Responses.** Exactly one response is produced per accepted request. It stays valid, with unchanged data, until `rsp_ready` is high. No further request is accepted while a response is outstanding.

Top module: `trace_ring_log`

## Requirements
- R1: After reset the write pointer, both read pointers and both freeze flags are zero, and neither port presents a response.
- R2: While logging runs, one `trace_data` entry is stored per clock at the write pointer, and the pointer then increments modulo DEPTH.
- R3: A read of the control/address register (`req_sel=0`) returns this 64-bit word:
  - bits 63:32 are the write pointer ORed with DEPTH;
  - bit 31 is this side's freeze flag;
  - bits log2(4*DEPTH)-1:0 are this side's read pointer;
  - all other bits are zero.
- R4: A write to the control/address register loads this side's read pointer from the low log2(4*DEPTH) bits and its freeze flag from bit 31. All other written bits, including the write-pointer field, have no effect.
- R5: A read of the data register (`req_sel=1`) works as follows:
  - it returns doubleword `p % 4` of entry `p / 4`, where `p` is the read pointer and doubleword 0 is bits 63:0;
  - the read pointer then increments modulo 4*DEPTH.
- R6: While either side's freeze flag is set, the write pointer and the buffer contents stay unchanged. Logging resumes once both flags are clear.
- R7: Each side has its own read pointer and freeze flag. Accesses by one side never change the other side's read pointer.
- R8: A response stays valid, with stable data, until `rsp_ready` is high. `req_ready` is low while a response is outstanding.
- R9: Data-register reads share one buffer read port. The processor side wins: in a cycle where both present a data read, only `cpu_req_ready` is high.
- R10: Response timing depends on the access:
  - a control/address access or a data write responds one cycle after acceptance;
  - a data read responds two cycles after acceptance.
- R11: A write to the data register changes nothing and is answered with zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trace_data | input | ENTRY_W | Status word sampled every cycle while logging runs |
| cpu_req_valid | input | 1 | Processor-side request valid |
| cpu_req_ready | output | 1 | Processor-side request accepted this cycle when valid |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_sel | input | 1 | 0 = control/address register, 1 = data register |
| cpu_req_wdata | input | 64 | Write data |
| cpu_rsp_valid | output | 1 | Processor-side response valid |
| cpu_rsp_ready | input | 1 | Processor side takes the response |
| cpu_rsp_rdata | output | 64 | Response data (zero for writes) |
| dbg_req_valid | input | 1 | Debug-side request valid |
| dbg_req_ready | output | 1 | Debug-side request accepted this cycle when valid |
| dbg_req_write | input | 1 | 1 = write, 0 = read |
| dbg_req_sel | input | 1 | 0 = control/address register, 1 = data register |
| dbg_req_wdata | input | 64 | Write data |
| dbg_rsp_valid | output | 1 | Debug-side response valid |
| dbg_rsp_ready | input | 1 | Debug side takes the response |
| dbg_rsp_rdata | output | 64 | Response data (zero for writes) |

## Verification
The bench builds the block with DEPTH=16 and the default 256-bit entries. At that depth the write pointer wraps within 16 cycles, and the read pointer wraps after 64 doublewords, so both wrap points are reached in a short run. With this depth the size marker lands on bit 36 of the control word, where a wrong OR or a wrong shift shows up at once. Because the depth is small, every entry is overwritten soon after reset, so the shadow copy of the buffer is fully known before any freeze.

// File: rtl/tlog_pkg.sv
package tlog_pkg;
  localparam int WORD_W  = 64;
  localparam int FRZ_BIT = 31;

  typedef enum logic [1:0] {
    PS_IDLE  = 2'd0,
    PS_FETCH = 2'd1,
    PS_RESP  = 2'd2
  } port_state_e;
endpackage

// File: rtl/tlog_store.sv
module tlog_store #(
  parameter int ENTRY_W = 256,
  parameter int DEPTH   = 2048,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               freeze,
  input  logic [ENTRY_W-1:0] trace_data,
  input  logic               rd_en,
  input  logic [AW-1:0]      rd_addr,
  output logic [ENTRY_W-1:0] rd_data,
  output logic [AW-1:0]      wr_ptr
);
  logic [ENTRY_W-1:0] mem [DEPTH];

  // Entry storage: read-first on a same-cycle collision
  always_ff @(posedge clk) begin
    if (rst_n && !freeze) mem[wr_ptr] <= trace_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end

  // Write pointer wraps by natural overflow (DEPTH is a power of two)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wr_ptr <= '0;
    else if (!freeze) wr_ptr <= wr_ptr + 1'b1;
  end

  // R2
  log_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !freeze |=> (wr_ptr == $past(wr_ptr) + 1'b1));

  // R6
  log_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> $stable(wr_ptr));
endmodule

// File: rtl/tlog_arb.sv
module tlog_arb #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] want,
  output logic [N-1:0] grant
);
  // Fixed priority: lowest index wins
  always_comb begin
    logic taken;
    taken = 1'b0;
    grant = '0;
    for (int i = 0; i < N; i++) begin
      if (want[i] && !taken) begin
        grant[i] = 1'b1;
        taken    = 1'b1;
      end
    end
  end

  // R9
  prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    want[0] |-> grant[0]);

  // R9
  single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((grant & ~want) == '0));
endmodule

// File: rtl/tlog_port.sv
module tlog_port
  import tlog_pkg::*;
#(
  parameter int ENTRY_W = 256,
  parameter int DEPTH   = 2048,
  localparam int AW     = $clog2(DEPTH),
  localparam int LANES  = ENTRY_W / WORD_W,
  localparam int LW     = $clog2(LANES),
  localparam int RPW    = $clog2(LANES * DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic               req_sel,
  input  logic [WORD_W-1:0]  req_wdata,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [WORD_W-1:0]  rsp_rdata,
  input  logic [AW-1:0]      wr_ptr,
  output logic               mem_want,
  input  logic               mem_grant,
  output logic [AW-1:0]      mem_addr,
  input  logic [ENTRY_W-1:0] mem_data,
  output logic               frz
);
  port_state_e       state;
  logic [RPW-1:0]    rd_ptr;
  logic [LW-1:0]     lane_q;
  logic [WORD_W-1:0] addr_word;
  logic [WORD_W-1:0] lane_word;
  logic              needs_mem;
  logic              accept;
  logic              unused_bits;

  assign unused_bits = ^{req_wdata[WORD_W-1:32], req_wdata[FRZ_BIT-1:RPW]};

  assign needs_mem = req_valid && !req_write && req_sel;
  assign mem_want  = (state == PS_IDLE) && needs_mem;
  assign req_ready = (state == PS_IDLE) && (!needs_mem || mem_grant);
  assign accept    = req_valid && req_ready;
  assign mem_addr  = rd_ptr[RPW-1:LW];
  assign rsp_valid = (state == PS_RESP);

  // Control word: write pointer with size marker, freeze flag, read pointer
  always_comb begin
    addr_word          = '0;
    addr_word[63:32]   = 32'(wr_ptr) | 32'(DEPTH);
    addr_word[FRZ_BIT] = frz;
    addr_word[RPW-1:0] = rd_ptr;
  end

  // Doubleword pick from the fetched entry
  always_comb begin
    lane_word = '0;
    for (int l = 0; l < LANES; l++) begin
      if (lane_q == LW'(l)) lane_word = mem_data[l*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= PS_IDLE;
      rd_ptr    <= '0;
      frz       <= 1'b0;
      lane_q    <= '0;
      rsp_rdata <= '0;
    end else begin
      unique case (state)
        PS_IDLE: begin
          if (accept) begin
            if (req_write) begin
              if (!req_sel) begin
                rd_ptr <= req_wdata[RPW-1:0];
                frz    <= req_wdata[FRZ_BIT];
              end
              rsp_rdata <= '0;
              state     <= PS_RESP;
            end else if (!req_sel) begin
              rsp_rdata <= addr_word;
              state     <= PS_RESP;
            end else begin
              lane_q <= rd_ptr[LW-1:0];
              rd_ptr <= rd_ptr + 1'b1;
              state  <= PS_FETCH;
            end
          end
        end
        PS_FETCH: begin
          rsp_rdata <= lane_word;
          state     <= PS_RESP;
        end
        PS_RESP: begin
          if (rsp_ready) state <= PS_IDLE;
        end
        default: state <= PS_IDLE;
      endcase
    end
  end

  // R8
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  // R8
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  // R5
  rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_write && req_sel) |=> (rd_ptr == $past(rd_ptr) + 1'b1));

  // R4
  addr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_write && !req_sel) |=>
      (rd_ptr == $past(req_wdata[RPW-1:0]) && frz == $past(req_wdata[FRZ_BIT])));

  // R11
  data_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_write && req_sel) |=> ($stable(rd_ptr) && $stable(frz)));

  // R10
  data_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_write && req_sel) |=> (!rsp_valid ##1 rsp_valid));

  // R10
  ctl_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !(!req_write && req_sel)) |=> rsp_valid);
endmodule

// File: rtl/trace_ring_log.sv
module trace_ring_log
  import tlog_pkg::*;
#(
  parameter int ENTRY_W = 256,
  parameter int DEPTH   = 2048
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRY_W-1:0] trace_data,
  input  logic               cpu_req_valid,
  output logic               cpu_req_ready,
  input  logic               cpu_req_write,
  input  logic               cpu_req_sel,
  input  logic [63:0]        cpu_req_wdata,
  output logic               cpu_rsp_valid,
  input  logic               cpu_rsp_ready,
  output logic [63:0]        cpu_rsp_rdata,
  input  logic               dbg_req_valid,
  output logic               dbg_req_ready,
  input  logic               dbg_req_write,
  input  logic               dbg_req_sel,
  input  logic [63:0]        dbg_req_wdata,
  output logic               dbg_rsp_valid,
  input  logic               dbg_rsp_ready,
  output logic [63:0]        dbg_rsp_rdata
);
  localparam int NSIDE = 2;
  localparam int AW    = $clog2(DEPTH);

  logic [NSIDE-1:0]  s_valid, s_ready, s_write, s_sel;
  logic [NSIDE-1:0]  s_rspv, s_rspr, s_want, s_grant, s_frz;
  logic [WORD_W-1:0] s_wdata [NSIDE];
  logic [WORD_W-1:0] s_rdata [NSIDE];
  logic [AW-1:0]     s_addr  [NSIDE];
  logic [AW-1:0]     wr_ptr;
  logic [AW-1:0]     mem_addr;
  logic [ENTRY_W-1:0] mem_data;
  logic              frozen;

  // Side 0 = processor (priority), side 1 = debug
  assign s_valid    = {dbg_req_valid, cpu_req_valid};
  assign s_write    = {dbg_req_write, cpu_req_write};
  assign s_sel      = {dbg_req_sel,   cpu_req_sel};
  assign s_rspr     = {dbg_rsp_ready, cpu_rsp_ready};
  assign s_wdata[0] = cpu_req_wdata;
  assign s_wdata[1] = dbg_req_wdata;

  assign cpu_req_ready = s_ready[0];
  assign dbg_req_ready = s_ready[1];
  assign cpu_rsp_valid = s_rspv[0];
  assign dbg_rsp_valid = s_rspv[1];
  assign cpu_rsp_rdata = s_rdata[0];
  assign dbg_rsp_rdata = s_rdata[1];

  assign frozen   = |s_frz;
  assign mem_addr = s_grant[0] ? s_addr[0] : s_addr[1];

  generate
    for (genvar g = 0; g < NSIDE; g++) begin : g_side
      tlog_port #(.ENTRY_W(ENTRY_W), .DEPTH(DEPTH)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (s_valid[g]),
        .req_ready (s_ready[g]),
        .req_write (s_write[g]),
        .req_sel   (s_sel[g]),
        .req_wdata (s_wdata[g]),
        .rsp_valid (s_rspv[g]),
        .rsp_ready (s_rspr[g]),
        .rsp_rdata (s_rdata[g]),
        .wr_ptr    (wr_ptr),
        .mem_want  (s_want[g]),
        .mem_grant (s_grant[g]),
        .mem_addr  (s_addr[g]),
        .mem_data  (mem_data),
        .frz       (s_frz[g])
      );
    end
  endgenerate

  tlog_arb #(.N(NSIDE)) u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .want  (s_want),
    .grant (s_grant)
  );

  tlog_store #(.ENTRY_W(ENTRY_W), .DEPTH(DEPTH)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .freeze     (frozen),
    .trace_data (trace_data),
    .rd_en      (|s_grant),
    .rd_addr    (mem_addr),
    .rd_data    (mem_data),
    .wr_ptr     (wr_ptr)
  );

  // R6
  either_frz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_valid && cpu_req_ready && cpu_req_write && !cpu_req_sel && cpu_req_wdata[FRZ_BIT])
      |=> ##1 $stable(wr_ptr));

  // R7
  dbg_ptr_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_valid && cpu_req_ready && !dbg_req_valid && !dbg_rsp_valid)
      |=> $stable(s_addr[1]));
endmodule

// File: tb/test_trace_ring_log.sv
module test_trace_ring_log;
  localparam int D   = 16;
  localparam int EW  = 256;
  localparam int NRP = 4 * D;

  typedef struct {
    logic [63:0] exp;
    int          acc;
    int          lat;
    string       tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [EW-1:0] trace_data = '0;
  logic cpu_req_valid = 0, cpu_req_write = 0, cpu_req_sel = 0, cpu_rsp_ready = 1;
  logic dbg_req_valid = 0, dbg_req_write = 0, dbg_req_sel = 0, dbg_rsp_ready = 1;
  logic [63:0] cpu_req_wdata = '0, dbg_req_wdata = '0;
  logic cpu_req_ready, cpu_rsp_valid, dbg_req_ready, dbg_rsp_valid;
  logic [63:0] cpu_rsp_rdata, dbg_rsp_rdata;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;
  logic [EW-1:0] shadow [D];
  int  wp = 0;
  int  rp [2] = '{0, 0};
  bit  frz [2] = '{0, 0};
  string cur_tag [2] = '{"R1", "R1"};
  item_t q0 [$];
  item_t q1 [$];
  bit prev_v [2] = '{0, 0};
  bit prev_r [2] = '{0, 0};
  logic [63:0] prev_d [2];
  int  first [2] = '{0, 0};
  bit  seen [2] = '{0, 0};
  int unsigned stamp = 0;

  trace_ring_log #(.ENTRY_W(EW), .DEPTH(D)) i_trace_ring_log (
    .clk(clk), .rst_n(rst_n), .trace_data(trace_data),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_write(cpu_req_write), .cpu_req_sel(cpu_req_sel),
    .cpu_req_wdata(cpu_req_wdata), .cpu_rsp_valid(cpu_rsp_valid),
    .cpu_rsp_ready(cpu_rsp_ready), .cpu_rsp_rdata(cpu_rsp_rdata),
    .dbg_req_valid(dbg_req_valid), .dbg_req_ready(dbg_req_ready),
    .dbg_req_write(dbg_req_write), .dbg_req_sel(dbg_req_sel),
    .dbg_req_wdata(dbg_req_wdata), .dbg_rsp_valid(dbg_rsp_valid),
    .dbg_rsp_ready(dbg_rsp_ready), .dbg_rsp_rdata(dbg_rsp_rdata)
  );

  always #5 clk = ~clk;

  function automatic logic [EW-1:0] mk(int unsigned st);
    logic [EW-1:0] v;
    for (int l = 0; l < EW / 64; l++) v[l*64 +: 64] = {st, 16'hC0DE, 16'(l)};
    return v;
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // Trace source: new word every cycle
  initial forever begin
    @(negedge clk);
    stamp++;
    trace_data = mk(stamp);
  end

  // Reference model and scoreboard, sampled 1 ns before each rising edge
  task automatic sample();
    bit old_frozen;
    cyc++;
    old_frozen = frz[0] | frz[1];
    for (int s = 0; s < 2; s++) begin
      logic v, r, w, sl, rv, rr;
      logic [63:0] wd, rd;
      item_t it;
      v  = s ? dbg_req_valid : cpu_req_valid;
      r  = s ? dbg_req_ready : cpu_req_ready;
      w  = s ? dbg_req_write : cpu_req_write;
      sl = s ? dbg_req_sel   : cpu_req_sel;
      wd = s ? dbg_req_wdata : cpu_req_wdata;
      rv = s ? dbg_rsp_valid : cpu_rsp_valid;
      rr = s ? dbg_rsp_ready : cpu_rsp_ready;
      rd = s ? dbg_rsp_rdata : cpu_rsp_rdata;
      if (v && r) begin
        it.acc = cyc; it.lat = 1; it.tag = cur_tag[s]; it.exp = '0;
        if (!w && !sl) begin
          it.exp[63:32] = 32'(wp) | 32'(D);
          it.exp[31]    = frz[s];
          it.exp[5:0]   = 6'(rp[s]);
        end else if (w && !sl) begin
          rp[s]  = int'(wd[5:0]);
          frz[s] = wd[31];
        end else if (!w && sl) begin
          it.exp = shadow[rp[s] / 4][64 * (rp[s] % 4) +: 64];
          it.lat = 2;
          rp[s]  = (rp[s] + 1) % NRP;
        end
        if (s == 0) q0.push_back(it); else q1.push_back(it);
      end
      // R8: held response
      if (prev_v[s] && !prev_r[s])
        chk(rv === 1'b1 && rd === prev_d[s], "R8 hold", rd, prev_d[s]);
      // R8: no acceptance while busy
      if (rv) chk(r === 1'b0, "R8 busy", 64'(r), 64'd0);
      if (rv && !seen[s]) begin first[s] = cyc; seen[s] = 1; end
      if (rv && rr) begin
        item_t got;
        bit empty;
        empty = (s == 0) ? (q0.size() == 0) : (q1.size() == 0);
        if (empty) chk(0, "R8 unexpected response", rd, 64'd0);
        else begin
          got = (s == 0) ? q0.pop_front() : q1.pop_front();
          chk(rd === got.exp, got.tag, rd, got.exp);
          chk(first[s] - got.acc == got.lat, "R10 latency",
              64'(first[s] - got.acc), 64'(got.lat));
        end
        seen[s] = 0;
      end
      prev_v[s] = rv; prev_r[s] = rr; prev_d[s] = rd;
    end
    if (!old_frozen) begin
      shadow[wp] = trace_data;
      wp = (wp + 1) % D;
    end
  endtask

  initial forever begin
    @(negedge clk);
    #4;
    if (rst_n && !done) sample();
  end

  task automatic issue(int s, bit wr, bit sel, logic [63:0] wd, string tag);
    bit ok;
    @(negedge clk);
    cur_tag[s] = tag;
    if (s == 0) begin
      cpu_req_valid = 1; cpu_req_write = wr; cpu_req_sel = sel; cpu_req_wdata = wd;
    end else begin
      dbg_req_valid = 1; dbg_req_write = wr; dbg_req_sel = sel; dbg_req_wdata = wd;
    end
    ok = 0;
    while (!ok) begin
      #4;
      ok = (s == 0) ? cpu_req_ready : dbg_req_ready;
      @(negedge clk);
    end
    if (s == 0) begin cpu_req_valid = 0; cpu_req_write = 0; cpu_req_sel = 0; end
    else        begin dbg_req_valid = 0; dbg_req_write = 0; dbg_req_sel = 0; end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      finish_up();
    end
  end

  initial begin
    for (int i = 0; i < D; i++) shadow[i] = '0;
    idle(2);
    #2;
    // R1: no response during reset
    chk(cpu_rsp_valid === 0 && dbg_rsp_valid === 0, "R1 reset",
        {62'd0, cpu_rsp_valid, dbg_rsp_valid}, 64'd0);
    idle(1);
    rst_n = 1;
    // R1: zeroed pointers/flags via control word
    issue(0, 0, 0, 64'd0, "R1");
    idle(40);
    // R2: write pointer after wrapping; R3: control word layout
    issue(0, 0, 0, 64'd0, "R2");
    issue(1, 0, 0, 64'd0, "R3");
    // R4: load read pointer 5 and freeze; junk bits ignored
    issue(0, 1, 0, 64'hFFFF_FFFF_8010_0005, "R4");
    issue(0, 0, 0, 64'd0, "R4");
    idle(10);
    // R6: frozen write pointer unchanged
    issue(0, 0, 0, 64'd0, "R6");
    // R5: doubleword reads across entry boundaries
    for (int k = 0; k < 8; k++) issue(0, 0, 1, 64'd0, "R5");
    // R5: read pointer wrap at 4*DEPTH
    issue(0, 1, 0, 64'h0000_0000_8000_003E, "R5");
    for (int k = 0; k < 3; k++) issue(0, 0, 1, 64'd0, "R5");
    issue(0, 0, 0, 64'd0, "R5");
    // R7: debug side independent
    issue(1, 0, 0, 64'd0, "R7");
    issue(1, 0, 1, 64'd0, "R7");
    issue(1, 0, 1, 64'd0, "R7");
    issue(0, 0, 0, 64'd0, "R7");
    // R11: data write has no effect
    issue(0, 1, 1, 64'h1234_5678_8000_0011, "R11");
    issue(0, 0, 0, 64'd0, "R11");
    idle(4);
    // R9: simultaneous data reads
    fork
      issue(0, 0, 1, 64'd0, "R9");
      issue(1, 0, 1, 64'd0, "R9");
      begin
        @(negedge clk);
        #2;
        chk(cpu_req_ready === 1 && dbg_req_ready === 0, "R9 priority",
            {62'd0, cpu_req_ready, dbg_req_ready}, 64'd2);
      end
    join
    idle(4);
    // R8: back-pressure on the response
    cpu_rsp_ready = 0;
    issue(0, 0, 0, 64'd0, "R8");
    idle(3);
    cpu_rsp_ready = 1;
    idle(3);
    // R6: debug freeze alone keeps logging halted
    issue(1, 1, 0, 64'h0000_0000_8000_0000, "R6");
    issue(0, 1, 0, 64'h0000_0000_0000_0001, "R6");
    idle(5);
    issue(0, 0, 0, 64'd0, "R6");
    issue(1, 1, 0, 64'd0, "R6");
    idle(7);
    // R2: logging resumed
    issue(0, 0, 0, 64'd0, "R2");
    idle(8);
    chk(q0.size() == 0 && q1.size() == 0, "R8 drained",
        64'(q0.size() + q1.size()), 64'd0);
    finish_up();
  end
endmodule